// File: doc/BRIEF.md
# Block-Cipher Job Sequencer

This block is the register-level controller for a 128-bit block-cipher engine on a plain 32-bit register bus. Software fills a key, an initial value and four input words. A job then starts in one of three ways: a software command, the fourth input word being written, or input word 0 alone being written. The block stays busy for a programmable number of cycles and then sets a data-ready flag. It also places the result in four output words. Which event clears the flag is selectable.

The cipher core itself is stood in for by an XOR with the 128-bit key register. The block chains it in three ways: ECB (direct), CBC (chained with the previous block) or counter mode (16-bit counter). This keeps the sequencing, the chaining and the data movement fully observable at the bus. The mode register is locked until the first write that carries an unlock code. A second input buffer can take the next block while the current job is still running.

Top module: `cipher_seq`

## Requirements
- R1: After reset, busy_o and ready_o are 0, and the mode register (0x04) and every output word read 0.
- R2: Until one mode write has been accepted, a mode write takes effect only if wdata[23:20] = 0xE. Later writes are accepted whatever those bits hold. Those bits always read 0. Mode fields: bit 0 encrypt(1)/decrypt(0), bit 3 dual buffer, bits 7:4 delay D, bits 9:8 start mode, bits 14:12 chaining, bit 15 clear-on-input.
- R3: ready_o rises exactly 12×(D+1) clock edges after the edge that accepts the start, and busy_o stays high in between.
- R4: In start mode 0, a job starts only when bit 0 of a write to offset 0x00 is 1 while idle.
- R5: In start mode 1, a job starts on the write that completes all four input words (offsets 0x40, 0x44, 0x48, 0x4C; word i is bits 32i+31:32i).
- R6: In start mode 2, a job starts on any idle write to input word 0.
- R7: Chaining code 0 (and the reserved codes 2, 3, 5, 6, 7) gives out = in XOR key. The key is written at 0x10–0x1C and outputs are read at 0x50–0x5C.
- R8: Chaining code 1 (CBC): encryption gives out = in XOR chain XOR key and then sets chain = out. Decryption gives the same output but sets chain = in. Chain is reloaded from the IV (0x20–0x2C) on every IV write.
- R9: Chaining code 4 (counter): out = in XOR key XOR {IV[127:16], ctr}. ctr is zeroed by any IV write and steps by one, modulo 2^16, per completed block.
- R10: With bit 15 = 0, ready clears on a read of any output word. With bit 15 = 1, output reads leave it set and any input-word write clears it.
- R11: With dual buffering off, input writes during a job are ignored.
- R12: With dual buffering on in start mode 2, input writes during a job go to a second buffer, and a word-0 write arms it. At completion, ready is set and the buffered block starts on the same edge, so busy_o stays high.
- R13: A mode write during a job takes effect when the job completes. Undefined offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr while rd_en is high |
| busy_o | output | 1 | Job in progress |
| ready_o | output | 1 | Data-ready flag |

## Verification
A start accepted on clock edge T raises ready_o on edge T+12×(D+1). The bench counts edges from the start-carrying write until ready_o is seen, and compares the count with that figure. For a buffered job, the count runs from the later bus access, so the expected figure is one fewer per extra access. Read data is combinational and is sampled just before the edge that carries the read. Flag and busy changes are sampled at the falling edge after the edge that causes them.

// File: rtl/cseq_pkg.sv
`timescale 1ns/1ps
package cseq_pkg;
    localparam int BLK_W = 128;
    localparam logic [2:0]  OP_CBC     = 3'd1;
    localparam logic [2:0]  OP_CTR     = 3'd4;
    localparam logic [1:0]  ST_MANUAL  = 2'd0;
    localparam logic [1:0]  ST_ALL4    = 2'd1;
    localparam logic [1:0]  ST_WORD0   = 2'd2;
    localparam logic [3:0]  UNLOCK_KEY = 4'hE;
    localparam logic [15:0] MODE_MASK  = 16'hF3F9;
    localparam logic [7:0]  A_CTRL     = 8'h00;
    localparam logic [7:0]  A_MODE     = 8'h04;
    localparam logic [7:0]  A_STAT     = 8'h08;
    localparam logic [3:0]  PG_KEY     = 4'h1;
    localparam logic [3:0]  PG_IV      = 4'h2;
    localparam logic [3:0]  PG_IN      = 4'h4;
    localparam logic [3:0]  PG_OUT     = 4'h5;
endpackage

// File: rtl/cseq_timer.sv
`timescale 1ns/1ps
module cseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    assign done = q.busy && (q.cnt == '0);
    assign busy = q.busy;

    always_comb begin
        d = q;
        if (load) begin
            d.busy = 1'b1;
            d.cnt  = load_val;
        end else if (done) begin
            d.busy = 1'b0;
        end else if (q.busy) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3: once running, busy holds until the count is exhausted
    a_r3_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !done) |=> q.busy);
endmodule

// File: rtl/cseq_xform.sv
`timescale 1ns/1ps
module cseq_xform
    import cseq_pkg::*;
(
    input  logic [2:0]       op,
    input  logic             encrypt,
    input  logic [BLK_W-1:0] blk_in,
    input  logic [BLK_W-1:0] key,
    input  logic [BLK_W-1:0] chain,
    input  logic [BLK_W-1:0] ctr_blk,
    output logic [BLK_W-1:0] blk_out,
    output logic [BLK_W-1:0] chain_nx
);
    always_comb begin
        chain_nx = chain;
        case (op)
            OP_CBC: begin
                blk_out  = blk_in ^ chain ^ key;
                chain_nx = encrypt ? blk_out : blk_in;
            end
            OP_CTR:  blk_out = blk_in ^ key ^ ctr_blk;
            default: blk_out = blk_in ^ key;
        endcase
    end
endmodule

// File: rtl/cipher_seq.sv
`timescale 1ns/1ps
module cipher_seq
    import cseq_pkg::*;
#(
    parameter int          CTR_W    = 16,
    parameter int          BASE_CYC = 12,
    parameter logic [127:0] KEY_RST = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        busy_o,
    output logic        ready_o
);
    localparam int CNT_W = $clog2(BASE_CYC * 16 + 1);

    typedef struct packed {
        logic [15:0]      mode;
        logic             unlocked;
        logic             pend_v;
        logic [15:0]      pend_mode;
        logic [BLK_W-1:0] din;
        logic [BLK_W-1:0] dbuf;
        logic             buf_go;
        logic [3:0]       wmask;
        logic [BLK_W-1:0] key;
        logic [BLK_W-1:0] iv;
        logic [BLK_W-1:0] chain;
        logic [CTR_W-1:0] ctr;
        logic [BLK_W-1:0] dout;
        logic             ready;
    } st_t;

    st_t q, n;
    logic             done, busy, start, restart, load;
    logic [CNT_W-1:0] load_val;
    logic [BLK_W-1:0] xf_out, xf_chain, ctr_blk;
    logic [1:0]       widx;
    logic [3:0]       pg;
    logic             aligned, wr_ctrl, wr_mode, wr_key, wr_iv, wr_in, rd_out;

    assign widx    = addr[3:2];
    assign pg      = addr[7:4];
    assign aligned = (addr[1:0] == 2'b00);
    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_mode = wr_en && (addr == A_MODE);
    assign wr_key  = wr_en && aligned && (pg == PG_KEY);
    assign wr_iv   = wr_en && aligned && (pg == PG_IV);
    assign wr_in   = wr_en && aligned && (pg == PG_IN);
    assign rd_out  = rd_en && aligned && (pg == PG_OUT);
    assign ctr_blk = {q.iv[BLK_W-1:CTR_W], q.ctr};

    cseq_xform u_xform (
        .op      (q.mode[14:12]),
        .encrypt (q.mode[0]),
        .blk_in  (q.din),
        .key     (q.key),
        .chain   (q.chain),
        .ctr_blk (ctr_blk),
        .blk_out (xf_out),
        .chain_nx(xf_chain)
    );

    cseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .busy    (busy),
        .done    (done)
    );

    always_comb begin
        n       = q;
        start   = 1'b0;
        restart = 1'b0;
        if (done) begin
            n.dout  = xf_out;
            n.chain = xf_chain;
            if (q.mode[14:12] == OP_CTR) n.ctr = q.ctr + 1'b1;
            n.ready = 1'b1;
            if (q.pend_v) begin
                n.mode   = q.pend_mode;
                n.pend_v = 1'b0;
            end
        end
        if (wr_mode && (q.unlocked || wdata[23:20] == UNLOCK_KEY)) begin
            n.unlocked = 1'b1;
            if (busy && !done) begin
                n.pend_v    = 1'b1;
                n.pend_mode = wdata[15:0] & MODE_MASK;
            end else begin
                n.mode = wdata[15:0] & MODE_MASK;
            end
        end
        if (wr_key) n.key[32*widx +: 32] = wdata;
        if (wr_iv) begin
            n.iv[32*widx +: 32] = wdata;
            n.chain = n.iv;
            n.ctr   = '0;
        end
        if (wr_in) begin
            if (!busy) begin
                n.din[32*widx +: 32] = wdata;
                n.wmask[widx]        = 1'b1;
                if (q.mode[9:8] == ST_WORD0 && widx == 2'd0) start = 1'b1;
                if (q.mode[9:8] == ST_ALL4 && (&n.wmask))    start = 1'b1;
            end else if (q.mode[3] && q.mode[9:8] == ST_WORD0) begin
                n.dbuf[32*widx +: 32] = wdata;
                if (widx == 2'd0) n.buf_go = 1'b1;
            end
            if (q.mode[15] && !done) n.ready = 1'b0;
        end
        if (wr_ctrl && wdata[0] && !busy && q.mode[9:8] == ST_MANUAL) start = 1'b1;
        if (rd_out && !q.mode[15] && !done) n.ready = 1'b0;
        if (done && n.buf_go) begin
            n.din    = n.dbuf;
            n.buf_go = 1'b0;
            restart  = 1'b1;
        end
        if (start) n.wmask = '0;
        load     = start || restart;
        load_val = CNT_W'(BASE_CYC * (int'(n.mode[7:4]) + 1) - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.key <= KEY_RST;
        end else begin
            q <= n;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == A_MODE)                rdata = {16'h0, q.mode};
            else if (addr == A_STAT)           rdata = {30'h0, busy, q.ready};
            else if (aligned && pg == PG_IN)   rdata = q.din[32*widx +: 32];
            else if (aligned && pg == PG_OUT)  rdata = q.dout[32*widx +: 32];
        end
    end

    assign busy_o  = busy;
    assign ready_o = q.ready;

    // R2: no mode field can be set before the unlocking write
    a_r2_locked_mode_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !q.unlocked |-> (q.mode == 16'h0));
    // R3: ready only rises out of a running job
    a_r3_ready_from_job: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(busy_o));
    // R7: results change only at completion
    a_r7_out_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(q.dout));
    // R11: input block frozen during a job
    a_r11_input_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done) |=> $stable(q.din));
    // R9: counter moves only on completion or IV write
    a_r9_ctr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !wr_iv) |=> $stable(q.ctr));
    // R13: undefined offset reads zero
    a_r13_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 8'hFC) |-> (rdata == 32'h0));
endmodule

// File: tb/cipher_seq_bench.sv
`timescale 1ns/1ps
module cipher_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        busy_o, ready_o;
    int          errors = 0;
    int          checks = 0;

    always #2 clk = ~clk;

    cipher_seq u_cipher_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy_o(busy_o), .ready_o(ready_o)
    );

    typedef struct packed {
        logic [31:0] mode;
        logic [31:0] din;
        logic [31:0] dout;
        logic [31:0] lat;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{32'h00E0_0001, 32'h1234_5678, 32'h1D3B_5977, 32'd12},
        '{32'h0000_0131, 32'hA5A5_A5A5, 32'hAAAA_AAAA, 32'd48},
        '{32'h0000_0200, 32'hFFFF_FFFF, 32'hF0F0_F0F0, 32'd12},
        '{32'h0000_20F0, 32'h0000_0000, 32'h0F0F_0F0F, 32'd192}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_ready(output int cnt);
        cnt = 0;
        while (!ready_o && cnt < 1000) begin
            @(posedge clk); @(negedge clk);
            cnt++;
        end
    endtask

    task automatic fill(input logic [31:0] d);
        for (int i = 3; i >= 0; i--) wr(8'h40 + 8'(4 * i), d);
    endtask

    task automatic run_manual(input logic [31:0] d);
        int c;
        fill(d);
        wr(8'h00, 32'h1);
        wait_ready(c);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int          c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy_o), 32'h0);
        chk("R1 ready", 32'(ready_o), 32'h0);
        rd(8'h04, v); chk("R1 mode", v, 32'h0);
        rd(8'h50, v); chk("R1 out0", v, 32'h0);
        // R2 lock
        wr(8'h04, 32'h0000_0131); rd(8'h04, v); chk("R2 locked write", v, 32'h0);
        wr(8'h04, 32'h00E0_0131); rd(8'h04, v); chk("R2 keyed write", v, 32'h0000_0131);
        wr(8'h04, 32'h0000_0001); rd(8'h04, v); chk("R2 later write", v, 32'h0000_0001);
        for (int i = 0; i < 4; i++) wr(8'h10 + 8'(4 * i), 32'h0F0F_0F0F);
        // table: R3 latency, R4/R5/R6 start modes, R7 ECB/reserved, R10 read clear
        for (int k = 0; k < 4; k++) begin
            wr(8'h04, VECS[k].mode);
            fill(VECS[k].din);
            if (VECS[k].mode[9:8] == 2'd0) wr(8'h00, 32'h1);
            chk("R4 R5 R6 started", 32'(busy_o), 32'h1);
            wait_ready(c);
            chk("R3 latency", 32'(c), VECS[k].lat);
            rd(8'h50, v); chk("R7 out0", v, VECS[k].dout);
            chk("R10 read clears", 32'(ready_o), 32'h0);
            rd(8'h5C, v); chk("R7 out3", v, VECS[k].dout);
        end
        // R4 ctrl write ignored outside manual mode
        wr(8'h04, 32'h0000_0100);
        wr(8'h00, 32'h1);
        chk("R4 no start in auto", 32'(busy_o), 32'h0);
        // R8 CBC encrypt then decrypt
        for (int i = 0; i < 4; i++) wr(8'h20 + 8'(4 * i), 32'h1111_1111);
        wr(8'h04, 32'h0000_1001);
        run_manual(32'h0); rd(8'h50, v); chk("R8 enc blk1", v, 32'h1E1E_1E1E);
        run_manual(32'h0); rd(8'h50, v); chk("R8 enc blk2", v, 32'h1111_1111);
        wr(8'h04, 32'h0000_1000);
        for (int i = 0; i < 4; i++) wr(8'h20 + 8'(4 * i), 32'h1111_1111);
        run_manual(32'h2222_2222); rd(8'h50, v); chk("R8 dec blk1", v, 32'h3C3C_3C3C);
        run_manual(32'h0); rd(8'h50, v); chk("R8 dec blk2", v, 32'h2D2D_2D2D);
        // R9 counter mode
        wr(8'h04, 32'h0000_4001);
        wr(8'h20, 32'h1111_1111);
        run_manual(32'h0); rd(8'h50, v); chk("R9 ctr0", v, 32'h1E1E_0F0F);
        run_manual(32'h0); rd(8'h50, v); chk("R9 ctr1", v, 32'h1E1E_0F0E);
        // R10 clear on input write
        wr(8'h04, 32'h0000_8001);
        run_manual(32'h0);
        rd(8'h50, v); chk("R10 lod out", v, 32'h0F0F_0F0F);
        chk("R10 read keeps ready", 32'(ready_o), 32'h1);
        wr(8'h44, 32'h0);
        chk("R10 input write clears", 32'(ready_o), 32'h0);
        // R11 writes ignored while busy
        wr(8'h04, 32'h0000_00F1);
        fill(32'h1234_5678);
        wr(8'h00, 32'h1);
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, v); chk("R11 input kept", v, 32'h1234_5678);
        wait_ready(c);
        rd(8'h50, v); chk("R11 result", v, 32'h1D3B_5977);
        // R12 dual buffer
        wr(8'h04, 32'h0000_0209);
        fill(32'h0000_00AA);
        wr(8'h40, 32'h0000_00BB);
        wait_ready(c);
        chk("R12 first latency", 32'(c), 32'd11);
        chk("R12 busy kept", 32'(busy_o), 32'h1);
        rd(8'h50, v); chk("R12 first out", v, 32'h0F0F_0FA5);
        wait_ready(c);
        chk("R12 second latency", 32'(c), 32'd11);
        rd(8'h50, v); chk("R12 second out", v, 32'h0F0F_0FB4);
        // R13 deferred mode write, undefined offsets
        wr(8'h04, 32'h0000_0011);
        fill(32'h0);
        wr(8'h00, 32'h1);
        wr(8'h04, 32'h0000_0001);
        rd(8'h04, v); chk("R13 mode held", v, 32'h0000_0011);
        wait_ready(c);
        rd(8'h04, v); chk("R13 mode applied", v, 32'h0000_0001);
        rd(8'hFC, v); chk("R13 undef read", v, 32'h0);
        wr(8'hFC, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R13 undef write", v, 32'h0000_0001);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule